// File: doc/BRIEF.md
# One-Shot Delayed Pulse Generator

This block makes one output pulse for each start event. Each pulse has a programmable delay before it and a programmable width. Two down-counters are chained. The delay counter is loaded from its reload value when an event is accepted, and it counts down once per clock. When it reads zero it raises a one-cycle interrupt. That interrupt loads the width counter from its own reload value and sets the pulse active. The pulse stays active until the width counter has run out.

A start event is either a selected edge on an external trigger pin or a software kick strobe. The trigger pin passes through a two-flop synchronizer before edge detection. The block runs only while its two enable bits are set. One start strobe sets both bits. One stop strobe clears both bits and freezes both counts and the pulse level.

While the block runs, the reload values and the pulse polarity are locked. The edge selection, the output enable and the software output level can be written at any time. When the output enable is clear, the output pin shows the software level. All ports are plain control and status signals. There is no data stream and no back-pressure.

Top module: `oneshot_delay_pulse`

## Requirements
- R1: After asynchronous reset, `en_o` is 00, both counts are 0, `mst_irq` is 0, `pulse_out` is 0, the output enable is 0, and the edge selection is falling.
- R2: `run_start` sets `en_o` to 11 on the next edge, and the block is then armed but not counting. `run_stop` clears `en_o` to 00 on the next edge. When both strobes arrive in the same cycle, stop wins.
- R3: A start event is accepted only while enabled. The sources are `sw_kick`, or a pin edge chosen by `edge_sel`: 00 falling, 01 rising, 10 both, 11 none. A kick loads the delay counter at the edge where it is sampled. A pin change loads the delay counter at the third clock edge after the change. Events while disabled are ignored.
- R4: On an accepted event the delay counter loads the delay reload value D and counts down once per clock. `mst_irq` is high for exactly one cycle, the cycle in which the count first reads 0. This is D cycles after the load. The count then holds at 0.
- R5: On the edge after `mst_irq` the width counter loads the width reload value W and the pulse becomes active. The pulse stays active for W+1 cycles, while the width count reads W down to 0, and then goes inactive.
- R6: With the output enable set, `pulse_out` is high when active if the polarity bit is 0, and low when active if the polarity bit is 1.
- R7: With the output enable clear, `pulse_out` equals the software level bit, whatever the counters do.
- R8: A start event that arrives while either counter is still counting is ignored. The running sequence and its timing are unchanged, and no extra interrupt follows.
- R9: After a stop, both counts and the pulse level stay frozen and no interrupt occurs. A later `run_start` re-arms the block and keeps the counts. Counting resumes only on a new event, which reloads from the reload values.
- R10: Writes to the delay reload, the width reload and the polarity bit are ignored while either enable bit is set. `edge_sel`, the output enable and the software level can be written at any time.
- R11: `mst_count` and `slv_count` always show the live counter values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, also the count clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| trig_pin | input | 1 | External trigger pin, asynchronous |
| edge_sel_we | input | 1 | Write strobe for the edge selection |
| edge_sel_wd | input | 2 | Edge selection: 00 fall, 01 rise, 10 both, 11 none |
| run_start | input | 1 | Start strobe for both channels |
| run_stop | input | 1 | Stop strobe for both channels |
| sw_kick | input | 1 | Software start event for the delay channel |
| dly_we | input | 1 | Write strobe for the delay reload value |
| dly_wd | input | WIDTH | Delay reload value |
| wid_we | input | 1 | Write strobe for the width reload value |
| wid_wd | input | WIDTH | Width reload value |
| pol_we | input | 1 | Write strobe for the polarity bit |
| pol_wd | input | 1 | Polarity: 0 active high, 1 active low |
| oe_we | input | 1 | Write strobe for the output enable |
| oe_wd | input | 1 | Output enable value |
| lvl_we | input | 1 | Write strobe for the software output level |
| lvl_wd | input | 1 | Software output level |
| en_o | output | 2 | Enable status, bit 0 delay channel, bit 1 width channel |
| mst_count | output | WIDTH | Live delay count |
| slv_count | output | WIDTH | Live width count |
| mst_irq | output | 1 | One-cycle delay-expired interrupt |
| pulse_out | output | 1 | Output pin |

## Verification
Several properties are checked on every cycle:
- the effect of the start and stop strobes on the enable bits;
- that the interrupt lasts one cycle and occurs only at a zero count;
- that the width counter loads and the pulse goes active on the edge after the interrupt;
- that counts and pulse stay frozen while stopped;
- that the reload values and the polarity stay locked while running.

The exact delay and width in cycles over a spread of reload values and both polarities can only be shown by the bench scenarios. The same holds for the synchronizer latency of pin edges under each edge selection, for rejection of events during a sequence, and for the software-level override.

// File: rtl/osp_pkg.sv
package osp_pkg;

  typedef enum logic [1:0] {
    EDGE_FALL = 2'b00,
    EDGE_RISE = 2'b01,
    EDGE_BOTH = 2'b10,
    EDGE_NONE = 2'b11
  } edge_sel_e;

  localparam int unsigned NUM_CH = 2;
  localparam int unsigned CH_DLY = 0;
  localparam int unsigned CH_WID = 1;

endpackage

// File: rtl/osp_edge_detect.sv
module osp_edge_detect
  import osp_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic      clk,
  input  logic      rst_n,
  input  logic      pin,
  input  edge_sel_e sel,
  output logic      hit
);

  logic [SYNC_STAGES-1:0] sync_q;
  logic                   prev_q;
  logic                   rise;
  logic                   fall;

  // Synchronizer chain followed by one history flop for edge detection.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
      prev_q <= 1'b0;
    end else begin
      sync_q <= {sync_q[SYNC_STAGES-2:0], pin};
      prev_q <= sync_q[SYNC_STAGES-1];
    end
  end

  assign rise =  sync_q[SYNC_STAGES-1] & ~prev_q;
  assign fall = ~sync_q[SYNC_STAGES-1] &  prev_q;

  always_comb begin
    unique case (sel)
      EDGE_FALL: hit = fall;
      EDGE_RISE: hit = rise;
      EDGE_BOTH: hit = rise | fall;
      default:   hit = 1'b0;
    endcase
  end

endmodule

// File: rtl/osp_down_counter.sv
module osp_down_counter #(
  parameter int unsigned WIDTH = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             clr,
  input  logic             load,
  input  logic [WIDTH-1:0] load_val,
  output logic [WIDTH-1:0] count,
  output logic             busy,
  output logic             done
);

  logic [WIDTH-1:0] cnt_q;
  logic             busy_q;

  // clr drops the busy flag but keeps the count; run gates all counting.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      busy_q <= 1'b0;
    end else if (clr) begin
      busy_q <= 1'b0;
    end else if (load) begin
      cnt_q  <= load_val;
      busy_q <= 1'b1;
    end else if (run && busy_q) begin
      if (cnt_q == '0) busy_q <= 1'b0;
      else             cnt_q  <= cnt_q - WIDTH'(1);
    end
  end

  assign count = cnt_q;
  assign busy  = busy_q;
  assign done  = run & busy_q & (cnt_q == '0);

endmodule

// File: rtl/osp_pulse_out.sv
module osp_pulse_out (
  input  logic clk,
  input  logic rst_n,
  input  logic set,
  input  logic clr,
  input  logic pol,
  input  logic oe,
  input  logic lvl,
  output logic pulse_q,
  output logic pin
);

  logic act_q;

  // Holds its level unless the width channel loads or expires.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   act_q <= 1'b0;
    else if (set) act_q <= 1'b1;
    else if (clr) act_q <= 1'b0;
  end

  assign pulse_q = act_q;
  assign pin     = oe ? (act_q ^ pol) : lvl;

endmodule

// File: rtl/oneshot_delay_pulse.sv
module oneshot_delay_pulse
  import osp_pkg::*;
#(
  parameter int unsigned WIDTH       = 16,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             trig_pin,
  input  logic             edge_sel_we,
  input  logic [1:0]       edge_sel_wd,
  input  logic             run_start,
  input  logic             run_stop,
  input  logic             sw_kick,
  input  logic             dly_we,
  input  logic [WIDTH-1:0] dly_wd,
  input  logic             wid_we,
  input  logic [WIDTH-1:0] wid_wd,
  input  logic             pol_we,
  input  logic             pol_wd,
  input  logic             oe_we,
  input  logic             oe_wd,
  input  logic             lvl_we,
  input  logic             lvl_wd,
  output logic [1:0]       en_o,
  output logic [WIDTH-1:0] mst_count,
  output logic [WIDTH-1:0] slv_count,
  output logic             mst_irq,
  output logic             pulse_out
);

  logic [NUM_CH-1:0] en_q;
  edge_sel_e         edge_sel_q;
  logic [WIDTH-1:0]  rl_q     [NUM_CH];
  logic              pol_q;
  logic              oe_q;
  logic              lvl_q;
  logic              running;
  logic              edge_hit;
  logic              trig_ok;
  logic              pulse_q;
  logic [NUM_CH-1:0] cnt_load;
  logic [NUM_CH-1:0] cnt_busy;
  logic [NUM_CH-1:0] cnt_done;
  logic [WIDTH-1:0]  cnt_val  [NUM_CH];

  assign running = |en_q;

  // Enable bits: both channels start and stop together, stop has priority.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         en_q <= '0;
    else if (run_stop)  en_q <= '0;
    else if (run_start) en_q <= '1;
  end

  // Settings that may change at any time.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      edge_sel_q <= EDGE_FALL;
      oe_q       <= 1'b0;
      lvl_q      <= 1'b0;
    end else begin
      if (edge_sel_we) edge_sel_q <= edge_sel_e'(edge_sel_wd);
      if (oe_we)       oe_q       <= oe_wd;
      if (lvl_we)      lvl_q      <= lvl_wd;
    end
  end

  // Settings locked while either channel is enabled.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rl_q[CH_DLY] <= '0;
      rl_q[CH_WID] <= '0;
      pol_q        <= 1'b0;
    end else if (!running) begin
      if (dly_we) rl_q[CH_DLY] <= dly_wd;
      if (wid_we) rl_q[CH_WID] <= wid_wd;
      if (pol_we) pol_q        <= pol_wd;
    end
  end

  osp_edge_detect #(
    .SYNC_STAGES(SYNC_STAGES)
  ) u_edge (
    .clk  (clk),
    .rst_n(rst_n),
    .pin  (trig_pin),
    .sel  (edge_sel_q),
    .hit  (edge_hit)
  );

  // An event is taken only when armed and idle, with no strobe this cycle.
  assign trig_ok = en_q[CH_DLY] & ~run_start & ~run_stop & ~|cnt_busy
                 & (sw_kick | edge_hit);

  assign cnt_load[CH_DLY] = trig_ok;
  assign cnt_load[CH_WID] = cnt_done[CH_DLY];

  for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_ch
    osp_down_counter #(
      .WIDTH(WIDTH)
    ) u_cnt (
      .clk     (clk),
      .rst_n   (rst_n),
      .run     (en_q[ch]),
      .clr     (run_start),
      .load    (cnt_load[ch]),
      .load_val(rl_q[ch]),
      .count   (cnt_val[ch]),
      .busy    (cnt_busy[ch]),
      .done    (cnt_done[ch])
    );
  end

  osp_pulse_out u_out (
    .clk    (clk),
    .rst_n  (rst_n),
    .set    (cnt_done[CH_DLY]),
    .clr    (cnt_done[CH_WID]),
    .pol    (pol_q),
    .oe     (oe_q),
    .lvl    (lvl_q),
    .pulse_q(pulse_q),
    .pin    (pulse_out)
  );

  assign en_o      = en_q;
  assign mst_count = cnt_val[CH_DLY];
  assign slv_count = cnt_val[CH_WID];
  assign mst_irq   = cnt_done[CH_DLY];

endmodule

// File: rtl/osp_checker.sv
module osp_checker #(
  parameter int unsigned WIDTH = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             run_start,
  input logic             run_stop,
  input logic [1:0]       en_o,
  input logic             mst_irq,
  input logic [WIDTH-1:0] mst_count,
  input logic [WIDTH-1:0] slv_count,
  input logic             pulse_q,
  input logic [WIDTH-1:0] dly_rl,
  input logic [WIDTH-1:0] wid_rl,
  input logic             pol_q
);

  assert_stop_clears_R2: assert property (@(posedge clk) disable iff (!rst_n)
    run_stop |=> en_o == 2'b00);

  assert_start_sets_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (run_start && !run_stop) |=> en_o == 2'b11);

  assert_irq_at_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
    mst_irq |-> mst_count == '0);

  assert_irq_single_R4: assert property (@(posedge clk) disable iff (!rst_n)
    mst_irq |=> !mst_irq);

  assert_width_load_R5: assert property (@(posedge clk) disable iff (!rst_n)
    mst_irq |=> (pulse_q && slv_count == $past(wid_rl)));

  assert_frozen_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (en_o == 2'b00 && !run_start) |=>
      ($stable(mst_count) && $stable(slv_count) && $stable(pulse_q)));

  assert_no_irq_stopped_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (en_o == 2'b00) |-> !mst_irq);

  assert_reload_locked_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (en_o != 2'b00) |=> ($stable(dly_rl) && $stable(wid_rl) && $stable(pol_q)));

endmodule

bind oneshot_delay_pulse osp_checker #(
  .WIDTH(WIDTH)
) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .run_start(run_start),
  .run_stop (run_stop),
  .en_o     (en_o),
  .mst_irq  (mst_irq),
  .mst_count(mst_count),
  .slv_count(slv_count),
  .pulse_q  (pulse_q),
  .dly_rl   (rl_q[0]),
  .wid_rl   (rl_q[1]),
  .pol_q    (pol_q)
);

// File: tb/sim_oneshot_delay_pulse.sv
`timescale 1ns/1ps
module sim_oneshot_delay_pulse;
  localparam int W = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic trig_pin = 0, edge_sel_we = 0, run_start = 0, run_stop = 0, sw_kick = 0;
  logic [1:0] edge_sel_wd = 2'b00;
  logic dly_we = 0, wid_we = 0, pol_we = 0, pol_wd = 0;
  logic oe_we = 0, oe_wd = 0, lvl_we = 0, lvl_wd = 0;
  logic [W-1:0] dly_wd = '0, wid_wd = '0;
  logic [1:0] en_o;
  logic [W-1:0] mst_count, slv_count;
  logic mst_irq, pulse_out;

  int checks = 0;
  int fails  = 0;

  always #2.5 clk = ~clk;

  oneshot_delay_pulse #(.WIDTH(W)) u0 (
    .clk(clk), .rst_n(rst_n), .trig_pin(trig_pin),
    .edge_sel_we(edge_sel_we), .edge_sel_wd(edge_sel_wd),
    .run_start(run_start), .run_stop(run_stop), .sw_kick(sw_kick),
    .dly_we(dly_we), .dly_wd(dly_wd), .wid_we(wid_we), .wid_wd(wid_wd),
    .pol_we(pol_we), .pol_wd(pol_wd), .oe_we(oe_we), .oe_wd(oe_wd),
    .lvl_we(lvl_we), .lvl_wd(lvl_wd), .en_o(en_o),
    .mst_count(mst_count), .slv_count(slv_count),
    .mst_irq(mst_irq), .pulse_out(pulse_out)
  );

  // Table of shots: delay, width, polarity.
  localparam int NV = 5;
  localparam int VEC_D [NV] = '{0, 1, 5, 12, 3};
  localparam int VEC_W [NV] = '{0, 3, 0, 7, 20};
  localparam int VEC_P [NV] = '{0, 0, 1, 0, 1};

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic do_start;
    run_start = 1; @(negedge clk); run_start = 0;
  endtask

  task automatic do_stop;
    run_stop = 1; @(negedge clk); run_stop = 0;
  endtask

  task automatic setup(input int d, input int w, input bit p);
    do_stop();
    dly_we = 1; dly_wd = W'(d); wid_we = 1; wid_wd = W'(w); pol_we = 1; pol_wd = p;
    @(negedge clk);
    dly_we = 0; wid_we = 0; pol_we = 0;
    do_start();
  endtask

  // Called at a negedge right after the event was driven; samples j = 1..span.
  task automatic measure(input int span, input int lat, input bit p,
                         output int f_irq, output int n_irq,
                         output int f_act, output int n_act, output int c_at);
    f_irq = -1; n_irq = 0; f_act = -1; n_act = 0; c_at = -1;
    for (int j = 1; j <= span; j++) begin
      @(negedge clk);
      if (j == 1) sw_kick = 0;
      if (j == lat) c_at = int'(mst_count);
      if (mst_irq) begin n_irq++; if (f_irq < 0) f_irq = j; end
      if (pulse_out != p) begin n_act++; if (f_act < 0) f_act = j; end
    end
  endtask

  task automatic set_edge(input logic [1:0] s);
    edge_sel_we = 1; edge_sel_wd = s; @(negedge clk); edge_sel_we = 0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    int fi, ni, fa, na, ca, c1;
    cyc(3);
    // R1 reset state
    chk("R1 en", int'(en_o), 0);
    chk("R1 mst_count", int'(mst_count), 0);
    chk("R1 slv_count", int'(slv_count), 0);
    chk("R1 irq", int'(mst_irq), 0);
    chk("R1 pulse", int'(pulse_out), 0);
    rst_n = 1;
    cyc(2);

    // R3 kick while disabled is ignored
    dly_we = 1; dly_wd = 16'd2; @(negedge clk); dly_we = 0;
    sw_kick = 1;
    measure(10, 1, 0, fi, ni, fa, na, ca);
    chk("R3 disabled kick irq", ni, 0);
    chk("R3 disabled count", int'(mst_count), 0);

    oe_we = 1; oe_wd = 1; @(negedge clk); oe_we = 0;

    // Table walk: R4 R5 R6 R11
    for (int v = 0; v < NV; v++) begin
      setup(VEC_D[v], VEC_W[v], VEC_P[v][0]);
      chk("R2 armed en", int'(en_o), 3);
      chk("R6 idle level", int'(pulse_out), VEC_P[v]);
      sw_kick = 1;
      measure(VEC_D[v] + VEC_W[v] + 8, 1, VEC_P[v][0], fi, ni, fa, na, ca);
      chk("R11 count after load", ca, VEC_D[v]);
      chk("R4 irq cycle", fi, VEC_D[v] + 1);
      chk("R4 irq count", ni, 1);
      chk("R5 pulse start", fa, VEC_D[v] + 2);
      chk("R5 pulse width", na, VEC_W[v] + 1);
      chk("R4 hold zero", int'(mst_count), 0);
    end

    // R8 events during delay and during pulse are ignored
    setup(10, 4, 0);
    sw_kick = 1; ni = 0; fi = -1;
    for (int j = 1; j <= 30; j++) begin
      @(negedge clk);
      sw_kick = (j == 4 || j == 13);
      if (mst_irq) begin ni++; if (fi < 0) fi = j; end
    end
    chk("R8 irq once", ni, 1);
    chk("R8 irq timing", fi, 11);

    // R3 pin edges through the synchronizer
    setup(2, 1, 0);
    set_edge(2'b01);
    trig_pin = 1; measure(12, 3, 0, fi, ni, fa, na, ca);
    chk("R3 rise fires", fi, 5);
    trig_pin = 0; measure(12, 3, 0, fi, ni, fa, na, ca);
    chk("R3 fall ignored under rise", ni, 0);
    set_edge(2'b10);
    trig_pin = 1; measure(12, 3, 0, fi, ni, fa, na, ca);
    chk("R3 both rise", fi, 5);
    trig_pin = 0; measure(12, 3, 0, fi, ni, fa, na, ca);
    chk("R3 both fall", fi, 5);
    set_edge(2'b00);
    trig_pin = 1; measure(12, 3, 0, fi, ni, fa, na, ca);
    chk("R3 rise ignored under fall", ni, 0);
    trig_pin = 0; measure(12, 3, 0, fi, ni, fa, na, ca);
    chk("R3 fall fires", fi, 5);
    chk("R3 fall count", ca, 2);
    set_edge(2'b11);
    trig_pin = 1; measure(12, 3, 0, fi, ni, fa, na, ca);
    chk("R3 none", ni, 0);
    trig_pin = 0; cyc(4);

    // R10 locked writes while running
    setup(4, 2, 0);
    dly_we = 1; dly_wd = 16'd9; wid_we = 1; wid_wd = 16'd9; pol_we = 1; pol_wd = 1;
    @(negedge clk);
    dly_we = 0; wid_we = 0; pol_we = 0;
    sw_kick = 1; measure(16, 1, 0, fi, ni, fa, na, ca);
    chk("R10 delay kept", fi, 5);
    chk("R10 width kept", na, 3);
    do_stop(); do_start();
    sw_kick = 1; measure(16, 1, 0, fi, ni, fa, na, ca);
    chk("R10 delay kept after restart", fi, 5);

    // R9 stop during delay freezes count
    setup(20, 5, 0);
    sw_kick = 1;
    for (int j = 1; j <= 5; j++) begin @(negedge clk); sw_kick = 0; end
    run_stop = 1; @(negedge clk); run_stop = 0;
    c1 = int'(mst_count);
    chk("R9 count at stop", c1, 15);
    chk("R2 stop en", int'(en_o), 0);
    measure(8, 1, 0, fi, ni, fa, na, ca);
    chk("R9 frozen count", int'(mst_count), 15);
    chk("R9 no irq stopped", ni, 0);
    do_start();
    measure(10, 1, 0, fi, ni, fa, na, ca);
    chk("R9 count kept on restart", int'(mst_count), 15);
    chk("R9 no resume without event", ni, 0);

    // R2 start and stop together: stop wins
    run_start = 1; run_stop = 1; @(negedge clk); run_start = 0; run_stop = 0;
    chk("R2 stop wins", int'(en_o), 0);

    // R9 stop during pulse holds level
    setup(1, 10, 0);
    sw_kick = 1;
    for (int j = 1; j <= 5; j++) begin @(negedge clk); sw_kick = 0; end
    run_stop = 1; @(negedge clk); run_stop = 0;
    chk("R9 width count at stop", int'(slv_count), 7);
    chk("R9 pulse held", int'(pulse_out), 1);
    cyc(6);
    chk("R9 width frozen", int'(slv_count), 7);
    chk("R9 pulse still held", int'(pulse_out), 1);
    do_start();
    sw_kick = 1; measure(20, 1, 0, fi, ni, fa, na, ca);
    chk("R5 pulse ends", int'(pulse_out), 0);

    // R7 software level override, then R6 polarity at idle
    setup(4, 2, 0);
    oe_we = 1; oe_wd = 0; lvl_we = 1; lvl_wd = 1; @(negedge clk); oe_we = 0; lvl_we = 0;
    chk("R7 level high", int'(pulse_out), 1);
    sw_kick = 1; measure(16, 1, 1, fi, ni, fa, na, ca);
    chk("R7 level unaffected", na, 0);
    lvl_we = 1; lvl_wd = 0; @(negedge clk); lvl_we = 0;
    chk("R7 level low", int'(pulse_out), 0);
    oe_we = 1; oe_wd = 1; @(negedge clk); oe_we = 0;
    chk("R6 idle active-high", int'(pulse_out), 0);
    setup(4, 2, 1);
    chk("R6 idle active-low", int'(pulse_out), 1);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule